// File: doc/BRIEF.md
# Postponable Auto-Refresh Scheduler

This block tells an SDRAM controller's command arbiter when a refresh is owed. An interval timer runs while the scheduler is enabled. Each time a full average refresh interval has elapsed, one more refresh becomes owed. The owed count is kept in a small counter. While that count is nonzero and no refresh is still in progress, the scheduler raises a normal request. The arbiter may leave that request pending while it serves other traffic. It can defer up to a posting limit of eight refreshes. When it defers that many, a ninth interval can pass before any refresh runs. The scheduler raises an urgent flag once the limit is reached, and the arbiter must not defer that request.

The arbiter sends an issue strobe when it puts the refresh command on the bus. If a request is being shown at that moment, the strobe is accepted. The owed count then drops by one, and a busy window of the refresh cycle time starts. While busy, the scheduler shows no request and ignores further strobes. A clock-enable hold output tells the power logic to keep the memory clock enable high. It covers the cycle in which the command is accepted and the whole busy window. If an interval elapses while the count is already at the limit, a sticky error flag is set. Only reset clears it. The interval length, the refresh cycle time and the posting limit are elaboration parameters.

Top module: `refresh_sched`

## Requirements
- R1: While and right after synchronous reset, req, urgent, busy, cke_hold and err are 0 and owed is 0.
- R2: With en high, owed rises by one after every INTERVAL_CYC consecutive enabled cycles, as long as no issue is accepted in the same cycle. The first rise comes INTERVAL_CYC cycles after en goes high. With en low, nothing accrues and the interval timer restarts from zero.
- R3: owed never exceeds POST_LIMIT. An interval that elapses at the limit with no accepted issue leaves owed at POST_LIMIT and sets err. err stays set until reset.
- R4: req is 1 exactly when en is 1, owed is nonzero and busy is 0.
- R5: urgent is 1 exactly when req is 1 and owed equals POST_LIMIT.
- R6: An issue strobe in a cycle with req high is accepted and lowers owed by one. A strobe while req is low changes neither owed nor busy.
- R7: If an interval elapses in the same cycle that an issue is accepted, owed is unchanged.
- R8: busy goes high in the cycle after an accepted issue and stays high for exactly TRFC_CYC cycles.
- R9: cke_hold is 1 in the cycle an issue is accepted and in every cycle in which busy is 1. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables interval accrual and requests |
| issued | input | 1 | Strobe from the arbiter: refresh command issued this cycle |
| req | output | 1 | Refresh owed and may be issued |
| urgent | output | 1 | Posting limit reached; must not be deferred further |
| busy | output | 1 | Refresh cycle time window running |
| cke_hold | output | 1 | Clock enable must stay high |
| owed | output | $clog2(POST_LIMIT+1) | Number of refreshes owed |
| err | output | 1 | Sticky: an interval elapsed with owed already at the limit |

## Verification
The checker checks these on every cycle: owed stays within its bound, err stays set once raised, no request is shown while busy, and urgent only appears together with req at the limit. It also checks how owed steps on an elapsed interval, on an accepted issue and on both together, and that busy and the clock-enable hold start after an acceptance. Some behaviour only the bench's scenarios can show: that the interval lasts exactly INTERVAL_CYC cycles, that the busy window has the right total length, and that strobes while busy or with nothing owed have no effect. The bench also drives the count to the limit and one interval past it, and lands an issue on the exact cycle an interval ends.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    typedef enum logic [1:0] {
        OWED_KEEP,
        OWED_INC,
        OWED_DEC,
        OWED_OVF
    } owed_op_e;

    typedef struct packed {
        logic pending;
        logic full;
    } owed_flags_t;

    function automatic owed_op_e owed_op(input logic tick, input logic take, input logic full);
        if (tick && !take) begin
            return full ? OWED_OVF : OWED_INC;
        end
        if (take && !tick) begin
            return OWED_DEC;
        end
        return OWED_KEEP;
    endfunction

endpackage

// File: rtl/refresh_sched_tick.sv
module refresh_sched_tick #(
    parameter int INTERVAL_CYC = 390
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int IW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;

    generate
        if (INTERVAL_CYC <= 1) begin : g_every
            assign tick = en;
        end else begin : g_count
            localparam logic [IW-1:0] LAST = IW'(INTERVAL_CYC - 1);
            logic [IW-1:0] cnt;

            assign tick = en && (cnt == LAST);

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (!en || tick) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/refresh_sched_owed.sv
module refresh_sched_owed
    import refresh_sched_pkg::*;
#(
    parameter int POST_LIMIT = 8,
    parameter int OW         = $clog2(POST_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          take,
    output logic [OW-1:0] owed,
    output owed_flags_t   flags,
    output logic          err
);
    localparam logic [OW-1:0] LIMIT = OW'(POST_LIMIT);

    owed_op_e op;

    assign flags.pending = (owed != '0);
    assign flags.full    = (owed == LIMIT);
    assign op            = owed_op(tick, take, flags.full);

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
            err  <= 1'b0;
        end else begin
            unique case (op)
                OWED_INC: owed <= owed + 1'b1;
                OWED_DEC: owed <= owed - 1'b1;
                OWED_OVF: err  <= 1'b1;
                default:  owed <= owed;
            endcase
        end
    end
endmodule

// File: rtl/refresh_sched_busy.sv
module refresh_sched_busy #(
    parameter int TRFC_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(TRFC_CYC + 1);
    localparam logic [TW-1:0] LOAD = TW'(TRFC_CYC);

    logic [TW-1:0] remain;

    assign busy = (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start) begin
            remain <= LOAD;
        end else if (busy) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int INTERVAL_CYC = 390,
    parameter int TRFC_CYC     = 4,
    parameter int POST_LIMIT   = 8,
    localparam int OW          = $clog2(POST_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          issued,
    output logic          req,
    output logic          urgent,
    output logic          busy,
    output logic          cke_hold,
    output logic [OW-1:0] owed,
    output logic          err
);
    logic        tick_w;
    logic        take_w;
    owed_flags_t flags_w;

    refresh_sched_tick #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (tick_w)
    );

    refresh_sched_owed #(.POST_LIMIT(POST_LIMIT), .OW(OW)) u_owed (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_w),
        .take  (take_w),
        .owed  (owed),
        .flags (flags_w),
        .err   (err)
    );

    refresh_sched_busy #(.TRFC_CYC(TRFC_CYC)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (take_w),
        .busy  (busy)
    );

    assign req      = en && flags_w.pending && !busy;
    assign take_w   = issued && req;
    assign urgent   = req && flags_w.full;
    assign cke_hold = busy || take_w;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int POST_LIMIT = 8,
    parameter int OW         = $clog2(POST_LIMIT + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          issued,
    input logic          req,
    input logic          urgent,
    input logic          busy,
    input logic          cke_hold,
    input logic [OW-1:0] owed,
    input logic          err,
    input logic          tick
);
    localparam logic [OW-1:0] LIMIT = OW'(POST_LIMIT);

    logic acc;
    assign acc = issued && req;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        owed <= LIMIT);

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    assert_overflow_sets_err_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !acc && owed == LIMIT) |=> (err && owed == LIMIT));

    assert_accrue_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !acc && owed < LIMIT) |=> (owed == $past(owed) + 1'b1));

    assert_no_req_busy_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req);

    assert_urgent_R5: assert property (@(posedge clk) disable iff (rst)
        urgent |-> (req && owed == LIMIT));

    assert_take_dec_R6: assert property (@(posedge clk) disable iff (rst)
        (acc && !tick) |=> (owed == $past(owed) - 1'b1));

    assert_coincide_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && tick) |=> $stable(owed));

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
        acc |=> busy);

    assert_cke_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> cke_hold);

    assert_cke_take_R9: assert property (@(posedge clk) disable iff (rst)
        acc |-> cke_hold);
endmodule

bind refresh_sched refresh_sched_chk #(.POST_LIMIT(POST_LIMIT), .OW(OW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .issued   (issued),
    .req      (req),
    .urgent   (urgent),
    .busy     (busy),
    .cke_hold (cke_hold),
    .owed     (owed),
    .err      (err),
    .tick     (tick_w)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
    localparam int I  = 20;
    localparam int T  = 3;
    localparam int L  = 8;
    localparam int OW = $clog2(L + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic issued = 1'b0;
    logic req, urgent, busy, cke_hold, err;
    logic [OW-1:0] owed;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    int m_cnt, m_owed, m_busy, m_err;
    string owed_tag;

    always #10 clk = ~clk;

    refresh_sched #(.INTERVAL_CYC(I), .TRFC_CYC(T), .POST_LIMIT(L)) u_refresh_sched (
        .clk(clk), .rst(rst), .en(en), .issued(issued),
        .req(req), .urgent(urgent), .busy(busy), .cke_hold(cke_hold),
        .owed(owed), .err(err)
    );

    function automatic int exp_req(input int e);
        return (e != 0 && m_owed != 0 && m_busy == 0) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_owed = 0; m_busy = 0; m_err = 0; owed_tag = "R2";
    endtask

    task automatic step(input logic e, input logic iss);
        int r, acc, tk;
        @(negedge clk);
        en = e;
        issued = iss;
        #1;
        r   = exp_req(e);
        acc = (iss && r != 0) ? 1 : 0;
        tk  = (e && m_cnt == I - 1) ? 1 : 0;
        chk("R4 req", int'(req), r);
        chk("R5 urgent", int'(urgent), (r != 0 && m_owed == L) ? 1 : 0);
        chk("R8 busy", int'(busy), (m_busy != 0) ? 1 : 0);
        chk("R9 cke_hold", int'(cke_hold), (m_busy != 0 || acc != 0) ? 1 : 0);
        chk({owed_tag, " owed"}, int'(owed), m_owed);
        chk("R3 err", int'(err), m_err);
        m_cnt = (!e || tk != 0) ? 0 : m_cnt + 1;
        if (tk != 0 && acc != 0) begin
            owed_tag = "R7";
        end else if (tk != 0) begin
            if (m_owed == L) begin m_err = 1; owed_tag = "R3"; end
            else begin m_owed++; owed_tag = "R2"; end
        end else if (acc != 0) begin
            m_owed--; owed_tag = "R6";
        end
        if (acc != 0) m_busy = T;
        else if (m_busy != 0) m_busy--;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; issued = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 req", int'(req), 0);
        chk("R1 urgent", int'(urgent), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 cke_hold", int'(cke_hold), 0);
        chk("R1 owed", int'(owed), 0);
        chk("R1 err", int'(err), 0);
        model_reset();
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        do_reset();

        // R2/R3/R5: accrue to the limit, then one interval past it
        for (int k = 0; k < 9 * I + 4; k++) step(1'b1, 1'b0);
        // R6: strobes with err already set still drain owed; hit busy window
        for (int k = 0; k < 12; k++) step(1'b1, 1'b1);

        do_reset();
        // R6: strobe with nothing owed is ignored
        for (int k = 0; k < 5; k++) step(1'b1, 1'b1);
        // R2: en low restarts the interval
        for (int k = 0; k < I / 2; k++) step(1'b1, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0);
        for (int k = 0; k < I + 2; k++) step(1'b1, 1'b0);
        // R7: issue on the exact cycle an interval ends
        for (int k = 0; k < 3 * I; k++)
            step(1'b1, (m_cnt == I - 1 && m_owed != 0 && m_busy == 0) ? 1'b1 : 1'b0);
        // R8: strobe right after acceptance lands in busy and is ignored
        for (int k = 0; k < 2 * I; k++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        for (int k = 0; k < T + 2; k++) step(1'b1, 1'b0);

        // random phase
        do_reset();
        for (int k = 0; k < 4000; k++)
            step(($urandom % 16) != 0, ($urandom % 100) < 8);
        do_reset();
        for (int k = 0; k < 4000; k++)
            step(($urandom % 8) != 0, ($urandom % 100) < 25);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule